// File: doc/BRIEF.md
# Single-Level Paging Address Translator

This block maps a 16-bit virtual address onto a 15-bit physical address through a sixteen-entry page table that is held entirely in flip-flops. The top four address bits pick a virtual page. The low twelve bits are the byte offset inside a 4 KB page, and they reach the physical address unchanged. Each table entry holds a three-bit frame number and a residency flag. Because there are only eight frames, at most half of the virtual space can be resident at any one time.

A table-load port lets the managing agent fill one entry per clock. The agent reacts to reported faults by moving a page in and then rewriting the entry. A request port accepts a virtual address together with a valid strobe. One clock later the block returns one of two results. The first is the physical address. The second is a fault pulse, together with the number of the virtual page that missed.

Top module: `pgx_translator`

## Requirements
- R1: For a request whose entry is resident, the block returns `rsp_paddr = {frame, req_vaddr[11:0]}`. The frame bits sit at [14:12] and the offset passes through at [11:0].
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low otherwise.
- R3: A request whose entry has its residency flag clear raises `rsp_fault` and drives `rsp_paddr` to zero instead of translating.
- R4: During a fault, `rsp_fault_vpn` carries bits [15:12] of the faulting request. It is zero whenever `rsp_fault` is low.
- R5: Synchronous reset (`rst_n` low at a clock edge) clears every residency flag, so every request faults until entries are loaded again.
- R6: A table write takes effect at the clock edge. A request in the same cycle that names the same entry sees the contents from before the write.
- R7: In a cycle with `rsp_valid` low, `rsp_paddr`, `rsp_fault` and `rsp_fault_vpn` are all zero.
- R8: With virtual page 0 loaded as frame 2 and resident, virtual address 0 translates to physical address 8192.
- R9: A table write changes only the entry named by `tbl_idx`. All other entries keep their frame and flag.
- R10: `rsp_fault` is never high unless `rsp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tbl_we | input | 1 | Load one table entry at this clock edge |
| tbl_idx | input | 4 | Virtual page whose entry is loaded |
| tbl_frame | input | 3 | Frame number to store |
| tbl_present | input | 1 | Residency flag to store |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 16 | Virtual address to translate |
| rsp_valid | output | 1 | Result available (one cycle after the request) |
| rsp_paddr | output | 15 | Physical address, zero on a fault |
| rsp_fault | output | 1 | Page-fault pulse |
| rsp_fault_vpn | output | 4 | Virtual page number of the fault |

## Verification
The hardest case to reach from the ports is a load and a lookup that hit the same entry in the same cycle. Here the old contents must win, including a change of residency in either direction. The stimulus drives a write and a request to one page on the same clock edge twice. The first write turns a resident page absent, and the second makes it resident with a new frame. After each, the bench repeats the lookup alone to see the new contents. Full sweeps of all sixteen pages follow every load pattern and a mid-run reset, so that a write or a reset that reaches the wrong entry is caught.

// File: rtl/pgx_pkg.sv
// Shared defaults for the paging translator.
// Assumes byte addressing and equal page and frame sizes.
package pgx_pkg;
    localparam int PGX_VA_W    = 16;  // virtual address width
    localparam int PGX_OFF_W   = 12;  // offset bits inside one page
    localparam int PGX_FRAME_W = 3;   // frame number width

    // Number of virtual pages for a given address split.
    function automatic int pgx_pages(input int va_w, input int off_w);
        return 1 << (va_w - off_w);
    endfunction
endpackage

// File: rtl/pgx_table.sv
// Page table held in flip-flops: one frame number and one residency flag per
// virtual page. There is one write port, applied at the clock edge, and one
// combinational read port.
// Assumes that reset clears all entries and that a read in the cycle of a
// write returns the old value.
module pgx_table #(
    parameter int VPN_W   = 4,
    parameter int FRAME_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [VPN_W-1:0]   wr_idx,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic               wr_present,
    input  logic [VPN_W-1:0]   rd_idx,
    output logic [FRAME_W-1:0] rd_frame,
    output logic               rd_present
);
    localparam int ENTRIES = 1 << VPN_W;

    logic [ENTRIES-1:0] present_q;
    logic [FRAME_W-1:0] frame_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic               pres_r;
        logic [FRAME_W-1:0] frm_r;

        // Hold one entry and load it when the write names this page.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pres_r <= 1'b0;
                frm_r  <= '0;
            end else if (wr_en && (wr_idx == VPN_W'(e))) begin
                pres_r <= wr_present;
                frm_r  <= wr_frame;
            end
        end

        assign present_q[e] = pres_r;
        assign frame_q[e]   = frm_r;
    end

    // Look up the entry selected by the request.
    always_comb begin
        rd_frame   = frame_q[rd_idx];
        rd_present = present_q[rd_idx];
    end
endmodule

// File: rtl/pgx_resp.sv
// Response stage: builds the physical address or the fault report from the
// looked-up entry and registers it, giving one cycle of latency.
// Assumes that the entry fields belong to the current req_vaddr.
module pgx_resp #(
    parameter int VA_W    = 16,
    parameter int OFF_W   = 12,
    parameter int FRAME_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [VA_W-1:0]            req_vaddr,
    input  logic [FRAME_W-1:0]         ent_frame,
    input  logic                       ent_present,
    output logic                       rsp_valid,
    output logic [FRAME_W+OFF_W-1:0]   rsp_paddr,
    output logic                       rsp_fault,
    output logic [VA_W-OFF_W-1:0]      rsp_fault_vpn
);
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PA_W  = FRAME_W + OFF_W;

    logic             hit_d;
    logic             miss_d;
    logic [PA_W-1:0]  paddr_d;
    logic [VPN_W-1:0] vpn_d;

    // Decide between translation and fault for the incoming request.
    always_comb begin
        hit_d   = req_valid && ent_present;
        miss_d  = req_valid && !ent_present;
        paddr_d = hit_d  ? {ent_frame, req_vaddr[OFF_W-1:0]} : '0;
        vpn_d   = miss_d ? req_vaddr[VA_W-1:OFF_W] : '0;
    end

    // Register the response so that it appears one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_paddr     <= '0;
            rsp_fault     <= 1'b0;
            rsp_fault_vpn <= '0;
        end else begin
            rsp_valid     <= req_valid;
            rsp_paddr     <= paddr_d;
            rsp_fault     <= miss_d;
            rsp_fault_vpn <= vpn_d;
        end
    end
endmodule

// File: rtl/pgx_translator.sv
// Single-level paging translator: a register-file page table followed by a
// registered response stage.
// Assumes that an external agent services faults by rewriting table entries.
module pgx_translator
    import pgx_pkg::*;
#(
    parameter int VA_W    = PGX_VA_W,
    parameter int OFF_W   = PGX_OFF_W,
    parameter int FRAME_W = PGX_FRAME_W,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int PA_W   = FRAME_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tbl_we,
    input  logic [VPN_W-1:0]   tbl_idx,
    input  logic [FRAME_W-1:0] tbl_frame,
    input  logic               tbl_present,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    output logic               rsp_valid,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic               rsp_fault,
    output logic [VPN_W-1:0]   rsp_fault_vpn
);
    logic [FRAME_W-1:0] lk_frame;
    logic               lk_present;

    pgx_table #(
        .VPN_W   (VPN_W),
        .FRAME_W (FRAME_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (tbl_we),
        .wr_idx     (tbl_idx),
        .wr_frame   (tbl_frame),
        .wr_present (tbl_present),
        .rd_idx     (req_vaddr[VA_W-1:OFF_W]),
        .rd_frame   (lk_frame),
        .rd_present (lk_present)
    );

    pgx_resp #(
        .VA_W    (VA_W),
        .OFF_W   (OFF_W),
        .FRAME_W (FRAME_W)
    ) u_resp (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .ent_frame     (lk_frame),
        .ent_present   (lk_present),
        .rsp_valid     (rsp_valid),
        .rsp_paddr     (rsp_paddr),
        .rsp_fault     (rsp_fault),
        .rsp_fault_vpn (rsp_fault_vpn)
    );
endmodule

// File: rtl/pgx_translator_chk.sv
// Port-level checker for the paging translator, attached through bind.
// Assumes a synchronous active-low reset held low from time zero.
module pgx_translator_chk #(
    parameter int VA_W    = 16,
    parameter int OFF_W   = 12,
    parameter int FRAME_W = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic [VA_W-1:0]          req_vaddr,
    input logic                     rsp_valid,
    input logic [FRAME_W+OFF_W-1:0] rsp_paddr,
    input logic                     rsp_fault,
    input logic [VA_W-OFF_W-1:0]    rsp_fault_vpn
);
    a_r2_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r2_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r1_offset_passes: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_fault || rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

    a_r4_fault_vpn_match: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!rsp_fault || rsp_fault_vpn == $past(req_vaddr[VA_W-1:OFF_W])));

    a_r3_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_paddr == '0));

    a_r4_vpn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_fault |-> (rsp_fault_vpn == '0));

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_paddr == '0 && !rsp_fault));

    a_r10_fault_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_valid);
endmodule

bind pgx_translator pgx_translator_chk #(
    .VA_W    (VA_W),
    .OFF_W   (OFF_W),
    .FRAME_W (FRAME_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .rsp_valid     (rsp_valid),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault),
    .rsp_fault_vpn (rsp_fault_vpn)
);

// File: tb/pgx_translator_tb.sv
// Self-checking bench: loads table patterns, sweeps every page at several
// offsets and compares against an arithmetic model of the requirements.
module pgx_translator_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [3:0]  tbl_idx = '0;
    logic [2:0]  tbl_frame = '0;
    logic        tbl_present = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_vaddr = '0;
    logic        rsp_valid;
    logic [14:0] rsp_paddr;
    logic        rsp_fault;
    logic [3:0]  rsp_fault_vpn;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    logic [2:0] m_frame [16];
    logic       m_pres  [16];

    always #4 clk = ~clk;  // 125 MHz

    pgx_translator u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tbl_we        (tbl_we),
        .tbl_idx       (tbl_idx),
        .tbl_frame     (tbl_frame),
        .tbl_present   (tbl_present),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .rsp_valid     (rsp_valid),
        .rsp_paddr     (rsp_paddr),
        .rsp_fault     (rsp_fault),
        .rsp_fault_vpn (rsp_fault_vpn)
    );

    // Compare packed {valid, fault, vpn, paddr} against the expected value.
    task automatic cmp(input string tag, input logic [20:0] exp);
        logic [20:0] act;
        act = {rsp_valid, rsp_fault, rsp_fault_vpn, rsp_paddr};
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: got v=%0b f=%0b vpn=%0h pa=%0h, expected v=%0b f=%0b vpn=%0h pa=%0h",
                     tag, act[20], act[19], act[18:15], act[14:0],
                     exp[20], exp[19], exp[18:15], exp[14:0]);
        end
    endtask

    // Expected response for a request, taken from the model table.
    function automatic logic [20:0] expect_for(input logic [15:0] va);
        logic [3:0] vp;
        vp = va[15:12];
        if (m_pres[vp]) return {1'b1, 1'b0, 4'h0, m_frame[vp], va[11:0]};
        return {1'b1, 1'b1, vp, 15'h0};
    endfunction

    task automatic load(input logic [3:0] idx, input logic [2:0] fr, input logic p);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = idx; tbl_frame = fr; tbl_present = p;
        @(negedge clk);
        tbl_we = 1'b0;
        m_frame[idx] = fr;
        m_pres[idx]  = p;
    endtask

    task automatic lookup(input string tag, input logic [15:0] va);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        cmp(tag, expect_for(va));
    endtask

    // Every page at four offsets.
    task automatic sweep(input string tag);
        for (int p = 0; p < 16; p++) begin
            lookup(tag, {p[3:0], 12'h000});
            lookup(tag, {p[3:0], 12'hFFF});
            lookup(tag, {p[3:0], 12'h5A5});
            lookup(tag, {p[3:0], 12'(p * 12'h111)});
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) begin
            m_frame[i] = '0;
            m_pres[i]  = 1'b0;
        end
    endtask

    // Watchdog: an expired run counts as a miscompare and still reports.
    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            misses++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R5 / R7: outputs idle after reset and every page faults.
        @(negedge clk);
        cmp("R7 reset idle", 21'h0);
        sweep("R5 R3 R4 all absent after reset");

        // R8: page 0 in frame 2 maps address 0 to 8192.
        load(4'h0, 3'd2, 1'b1);
        lookup("R8 example", 16'h0000);
        if (rsp_paddr !== 15'd8192) begin
            misses++;
            $display("FAIL R8: got %0d expected 8192", rsp_paddr);
        end
        vectors++;

        // Pattern A: scattered frames, every fourth page absent.
        for (int p = 0; p < 16; p++)
            load(p[3:0], 3'((p * 3 + 1) & 7), (p % 4) != 3);
        sweep("R1 R3 R4 pattern A");

        // Pattern B: complement residency, new frames.
        for (int p = 0; p < 16; p++)
            load(p[3:0], 3'((7 - p) & 7), (p % 4) == 3);
        sweep("R1 R3 R4 pattern B");

        // R9: rewrite one entry, the others must be unchanged.
        load(4'h9, 3'd5, 1'b1);
        sweep("R9 single write isolation");

        // R6: write and lookup of the same page in one cycle, resident to absent.
        load(4'h6, 3'd4, 1'b1);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = 4'h6; tbl_frame = 3'd1; tbl_present = 1'b0;
        req_valid = 1'b1; req_vaddr = 16'h6ABC;
        @(negedge clk);
        tbl_we = 1'b0; req_valid = 1'b0;
        cmp("R6 old entry used (was resident)", {1'b1, 1'b0, 4'h0, 3'd4, 12'hABC});
        m_frame[6] = 3'd1; m_pres[6] = 1'b0;
        lookup("R6 new entry visible (absent)", 16'h6ABC);

        // R6: absent to resident in the same cycle.
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = 4'h6; tbl_frame = 3'd7; tbl_present = 1'b1;
        req_valid = 1'b1; req_vaddr = 16'h6123;
        @(negedge clk);
        tbl_we = 1'b0; req_valid = 1'b0;
        cmp("R6 old entry used (was absent)", {1'b1, 1'b1, 4'h6, 15'h0});
        m_frame[6] = 3'd7; m_pres[6] = 1'b1;
        lookup("R6 new entry visible (resident)", 16'h6123);

        // R2 / R7 / R10: back-to-back requests, then an idle cycle.
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 16'h6001;
        @(negedge clk);
        cmp("R2 back-to-back first", expect_for(16'h6001));
        req_vaddr = 16'h3002;
        @(negedge clk);
        cmp("R2 R10 back-to-back second", expect_for(16'h3002));
        req_valid = 1'b0;
        @(negedge clk);
        cmp("R2 R7 idle after burst", 21'h0);

        // R7: a table write alone produces no response.
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = 4'h2; tbl_frame = 3'd3; tbl_present = 1'b1;
        @(negedge clk);
        tbl_we = 1'b0;
        m_frame[2] = 3'd3; m_pres[2] = 1'b1;
        cmp("R7 write without request", 21'h0);
        lookup("R9 written entry", 16'h2FED);

        // R5: reset in mid-run clears residency again.
        do_reset();
        @(negedge clk);
        cmp("R5 R7 idle after second reset", 21'h0);
        sweep("R5 all absent after second reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule